// File: doc/BRIEF.md
# Control register bank with bit-set, bit-clear and bit-invert write slots

This block is a 32-bit control register bank for a larger chip. Software reaches it through a plain word-addressed bus. Downstream logic reads every stored register at once through two wide parallel outputs.

The bank covers a 0x8000-byte span, decoded as two windows:

- **Plain window.** Starts at byte offset 0 and holds ordinary read/write words.
- **Aliased window.** Starts at byte offset 0x4000. Any word in it may be named, through a parameter list, as the base of a four-word group.

A four-word group works as follows:

- The first word of the group is the register itself.
- The next three words are write slots that set, clear or invert bits of that register in place. This removes any need for a read-modify-write sequence.
- Reading any of the three slots returns the register it belongs to.

Registers flagged as lock-carrying come out of reset with a fixed lock bit forced high. This holds no matter what their reset value is.

The bus address is the word index, meaning the byte offset shifted right by two. Only whole, aligned 32-bit words are transferred. An access that falls outside both implemented ranges does the following:

- It reads as zero.
- It changes nothing.
- It produces a single-cycle error pulse.

Top module: `ctl_alias_regbank`

## Requirements
- R1: The address is a 13-bit word index (byte offset >> 2, span 0x8000 bytes). Plain registers occupy word indices 0 to N_PLAIN-1. The aliased window occupies word indices 0x1000 to 0x1000+N_ALIAS-1, which is byte offset 0x4000.
- R2: A write to a plain-window word, or to any aliased-window word that is not a set, clear or toggle slot, stores all 32 data bits. The new value appears on the read data and on the parallel output after the clock edge that samples the write.
- R3: For each listed base b in the aliased window, a write to word b+1 ORs the write data into register b.
- R4: A write to word b+2 clears in register b every bit that is 1 in the write data, giving register AND NOT data.
- R5: A write to word b+3 XORs the write data into register b.
- R6: A read of word b+1, b+2 or b+3 returns the current value of register b. The parallel output lanes for slot words are always zero.
- R7: An aliased-window word that is neither a listed base nor one of its three slots behaves as a plain register.
- R8: On reset every register loads its parameterised reset value. Registers flagged in LOCK_MASK additionally have bit LOCK_BIT (default 31) forced to 1, even after software has cleared it.
- R9: A read or write to an index outside both implemented ranges has the following effects:
  - read data is zero;
  - no register changes;
  - err_o is 1 for exactly the one cycle after the clock edge that sampled the access.
- R10: A read in the same cycle as a write to the same register returns the value held before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| addr_i | input | 13 | Word index (byte offset >> 2) |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe; only used to flag out-of-range reads |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for addr_i |
| err_o | output | 1 | One-cycle pulse after an out-of-range access |
| plain_regs_o | output | 128 | All plain registers, word k in bits [32k+31:32k] |
| alias_regs_o | output | 320 | All aliased-window words, slot words read as zero |

## Verification
The bench sweeps every implemented word with several data patterns and compares every readable address and every output lane after each write. This sweep catches three kinds of error:

- a slot that decodes onto the wrong base or applies the wrong operation, for example OR where AND NOT was required;
- a plain word that was treated as a slot;
- a write that leaks into a neighbouring register.

Out-of-range probes sit just past each window edge and at the top of the span. These probes show whether a decoder with an off-by-one bound writes into a phantom register, or whether the error pulse is missing or stretched.

A same-cycle read/write probe exposes read data that bypasses to the new value. A second reset, issued after the lock bit has been cleared through its clear slot, shows whether the lock is truly forced or merely part of a stored value.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  // Update operation; the encoding equals the slot offset above the base word.
  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLR   = 2'd2,
    OP_TOG   = 2'd3
  } upd_op_e;

  localparam int unsigned SLOTS_PER_GROUP = 4;
endpackage

// File: rtl/regbank_rst_sync.sv
module regbank_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/regbank_decode.sv
module regbank_decode
  import regbank_pkg::*;
#(
  parameter int unsigned AW             = 13,
  parameter int unsigned N_PLAIN        = 4,
  parameter int unsigned N_ALIAS        = 10,
  parameter int unsigned ALIAS_WIN_WORD = 32'h1000,
  parameter int unsigned NUM_BASES      = 2,
  parameter int unsigned ALIAS_BASES [NUM_BASES] = '{0, 4}
) (
  input  logic [AW-1:0] addr_i,
  output logic          hit_o,
  output logic          alias_o,
  output logic [AW-1:0] tgt_o,
  output upd_op_e       op_o
);
  localparam logic [AW-1:0] PLAIN_END = AW'(N_PLAIN);
  localparam logic [AW-1:0] ALIAS_LO  = AW'(ALIAS_WIN_WORD);
  localparam logic [AW-1:0] ALIAS_HI  = AW'(ALIAS_WIN_WORD + N_ALIAS);

  logic          in_plain;
  logic          in_alias;
  logic [AW-1:0] off;
  logic [AW-1:0] diff;

  always_comb begin
    in_plain = (addr_i < PLAIN_END);
    in_alias = (addr_i >= ALIAS_LO) && (addr_i < ALIAS_HI);
    off      = addr_i - ALIAS_LO;
    diff     = '0;
    op_o     = OP_WRITE;
    tgt_o    = in_alias ? off : addr_i;
    if (in_alias) begin
      for (int j = 0; j < NUM_BASES; j++) begin
        if ((off > AW'(ALIAS_BASES[j])) &&
            (off < AW'(ALIAS_BASES[j] + SLOTS_PER_GROUP))) begin
          diff  = off - AW'(ALIAS_BASES[j]);
          tgt_o = AW'(ALIAS_BASES[j]);
          op_o  = upd_op_e'(diff[1:0]);
        end
      end
    end
    hit_o   = in_plain || in_alias;
    alias_o = in_alias;
  end
endmodule

// File: rtl/regbank_cell.sv
module regbank_cell
  import regbank_pkg::*;
#(
  parameter int unsigned   DW      = 32,
  parameter logic [DW-1:0] RST_VAL = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  upd_op_e       op,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  logic [DW-1:0] d_nxt;

  always_comb begin
    unique case (op)
      OP_SET:  d_nxt = q | wdata;
      OP_CLR:  d_nxt = q & ~wdata;
      OP_TOG:  d_nxt = q ^ wdata;
      default: d_nxt = wdata;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= RST_VAL;
    else if (wr_en) q <= d_nxt;
  end

  // R2
  plain_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op == OP_WRITE) |=> (q == $past(wdata)));
  // R3
  set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op == OP_SET) |=> ((q & $past(wdata)) == $past(wdata)));
  // R4
  clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op == OP_CLR) |=> ((q & $past(wdata)) == '0));
  // R5
  tog_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op == OP_TOG) |=> (q == ($past(q) ^ $past(wdata))));
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q));
endmodule

// File: rtl/ctl_alias_regbank.sv
module ctl_alias_regbank
  import regbank_pkg::*;
#(
  parameter int unsigned DW             = 32,
  parameter int unsigned AW             = 13,
  parameter int unsigned N_PLAIN        = 4,
  parameter int unsigned N_ALIAS        = 10,
  parameter int unsigned ALIAS_WIN_BYTE = 32'h4000,
  parameter int unsigned NUM_BASES      = 2,
  parameter int unsigned ALIAS_BASES [NUM_BASES] = '{0, 4},
  parameter int unsigned LOCK_BIT       = 31,
  parameter logic [N_ALIAS-1:0] LOCK_MASK = 10'b00_0001_0001,
  parameter logic [31:0] PLAIN_RST [N_PLAIN] =
    '{32'h1111_0001, 32'h0000_0000, 32'hA5A5_0000, 32'h0000_00FF},
  parameter logic [31:0] ALIAS_RST [N_ALIAS] =
    '{32'h0001_3001, 32'h0, 32'h0, 32'h0, 32'h1018_101B,
      32'h0, 32'h0, 32'h0, 32'h0000_0012, 32'hFFFF_0000}
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [AW-1:0]         addr_i,
  input  logic                  we_i,
  input  logic                  re_i,
  input  logic [DW-1:0]         wdata_i,
  output logic [DW-1:0]         rdata_o,
  output logic                  err_o,
  output logic [N_PLAIN*DW-1:0] plain_regs_o,
  output logic [N_ALIAS*DW-1:0] alias_regs_o
);
  localparam int unsigned ALIAS_WIN_WORD = ALIAS_WIN_BYTE >> 2;
  localparam logic [DW-1:0] LOCK_ONE = DW'(1) << LOCK_BIT;

  function automatic bit is_slot(int k);
    for (int j = 0; j < NUM_BASES; j++) begin
      if ((k > int'(ALIAS_BASES[j])) &&
          (k < int'(ALIAS_BASES[j] + SLOTS_PER_GROUP))) return 1'b1;
    end
    return 1'b0;
  endfunction

  logic          rst_sync_n;
  logic          hit;
  logic          in_alias;
  logic [AW-1:0] tgt;
  upd_op_e       op;
  logic          err_d;
  logic [DW-1:0] plain_q [N_PLAIN];
  logic [DW-1:0] alias_q [N_ALIAS];

  regbank_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  regbank_decode #(
    .AW             (AW),
    .N_PLAIN        (N_PLAIN),
    .N_ALIAS        (N_ALIAS),
    .ALIAS_WIN_WORD (ALIAS_WIN_WORD),
    .NUM_BASES      (NUM_BASES),
    .ALIAS_BASES    (ALIAS_BASES)
  ) u_decode (
    .addr_i  (addr_i),
    .hit_o   (hit),
    .alias_o (in_alias),
    .tgt_o   (tgt),
    .op_o    (op)
  );

  for (genvar k = 0; k < N_PLAIN; k++) begin : g_plain
    logic wr_en;
    assign wr_en = we_i && hit && !in_alias && (tgt == AW'(k));
    regbank_cell #(.DW(DW), .RST_VAL(DW'(PLAIN_RST[k]))) u_cell (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .wr_en (wr_en),
      .op    (OP_WRITE),
      .wdata (wdata_i),
      .q     (plain_q[k])
    );
    assign plain_regs_o[k*DW +: DW] = plain_q[k];
  end

  for (genvar k = 0; k < N_ALIAS; k++) begin : g_alias
    if (is_slot(k)) begin : g_slot
      assign alias_q[k] = '0;
    end else begin : g_store
      localparam logic [DW-1:0] RV =
        DW'(ALIAS_RST[k]) | (LOCK_MASK[k] ? LOCK_ONE : '0);
      logic wr_en;
      assign wr_en = we_i && hit && in_alias && (tgt == AW'(k));
      regbank_cell #(.DW(DW), .RST_VAL(RV)) u_cell (
        .clk   (clk),
        .rst_n (rst_sync_n),
        .wr_en (wr_en),
        .op    (op),
        .wdata (wdata_i),
        .q     (alias_q[k])
      );
    end
    assign alias_regs_o[k*DW +: DW] = alias_q[k];
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < N_PLAIN; k++) begin
      if (hit && !in_alias && tgt == AW'(k)) rdata_o = plain_q[k];
    end
    for (int k = 0; k < N_ALIAS; k++) begin
      if (in_alias && tgt == AW'(k)) rdata_o = alias_q[k];
    end
    err_d = (we_i || re_i) && !hit;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) err_o <= 1'b0;
    else             err_o <= err_d;
  end

  // R9
  oor_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (we_i && !hit) |=> ($stable(plain_regs_o) && $stable(alias_regs_o)));
  // R6
  slot_read_base_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_alias && op != OP_WRITE) |-> (rdata_o == alias_regs_o[tgt*DW +: DW]));
endmodule

// File: tb/test_ctl_alias_regbank.sv
module test_ctl_alias_regbank;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [12:0]  addr = '0;
  logic         we = 1'b0;
  logic         re = 1'b0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic         err;
  logic [127:0] plain_regs;
  logic [319:0] alias_regs;

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] mp [4];
  logic [31:0] ma [10];

  always #10 clk = ~clk;

  ctl_alias_regbank i_ctl_alias_regbank (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr_i       (addr),
    .we_i         (we),
    .re_i         (re),
    .wdata_i      (wdata),
    .rdata_o      (rdata),
    .err_o        (err),
    .plain_regs_o (plain_regs),
    .alias_regs_o (alias_regs)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    mp[0] = 32'h1111_0001; mp[1] = 32'h0; mp[2] = 32'hA5A5_0000; mp[3] = 32'h0000_00FF;
    foreach (ma[i]) ma[i] = 32'h0;
    ma[0] = 32'h8001_3001;  // lock bit 31 forced
    ma[4] = 32'h9018_101B;  // lock bit 31 forced
    ma[8] = 32'h0000_0012;
    ma[9] = 32'hFFFF_0000;
  endtask

  function automatic int base_of(input int off);
    if (off >= 1 && off <= 3) return 0;
    if (off >= 5 && off <= 7) return 4;
    return off;
  endfunction

  task automatic model_write(input logic [12:0] a, input logic [31:0] d);
    int off, b;
    if (a < 13'd4) mp[a] = d;
    else if (a >= 13'h1000 && a < 13'h100A) begin
      off = int'(a) - 32'h1000;
      b = base_of(off);
      case (off - b)
        1: ma[b] = ma[b] | d;
        2: ma[b] = ma[b] & ~d;
        3: ma[b] = ma[b] ^ d;
        default: ma[b] = d;
      endcase
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [12:0] a);
    if (a < 13'd4) return mp[a];
    if (a >= 13'h1000 && a < 13'h100A) return ma[base_of(int'(a) - 32'h1000)];
    return 32'h0;
  endfunction

  task automatic bus_write(input logic [12:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    model_write(a, d);
  endtask

  task automatic check_all(input string req);
    for (int k = 0; k < 4; k++) begin
      chk(req, plain_regs[k*32 +: 32], mp[k]);
      @(negedge clk); addr = 13'(k); #1;
      chk(req, rdata, exp_read(13'(k)));
    end
    for (int k = 0; k < 10; k++) begin
      chk(req, alias_regs[k*32 +: 32], ma[k]);
      @(negedge clk); addr = 13'h1000 + 13'(k); #1;
      chk(req, rdata, exp_read(13'h1000 + 13'(k)));
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_reset();
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] pats [4];
    logic [12:0] oor [5];
    string tag;
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h0000_0000;
    pats[2] = 32'hA5A5_5A5A; pats[3] = 32'h8000_0001;
    oor[0] = 13'h0004; oor[1] = 13'h0FFF; oor[2] = 13'h100A;
    oor[3] = 13'h1FFF; oor[4] = 13'h0800;

    do_reset();
    // R8: reset values including forced lock bits
    check_all("R8 reset");
    chk("R9 err idle", {31'b0, err}, 32'h0);

    // R1 R2: plain window sweep
    for (int k = 0; k < 4; k++)
      for (int p = 0; p < 4; p++) begin
        bus_write(13'(k), pats[p] ^ 32'(k));
        check_all("R2 plain/R1 map");
      end

    // R3 R4 R5 R6 R7: aliased window sweep over every word
    for (int k = 0; k < 10; k++)
      for (int p = 0; p < 4; p++) begin
        case (k)
          1, 5: tag = "R3 set slot/R6";
          2, 6: tag = "R4 clear slot/R6";
          3, 7: tag = "R5 toggle slot/R6";
          8, 9: tag = "R7 unlisted plain";
          default: tag = "R2 base write";
        endcase
        bus_write(13'h1000 + 13'(k), pats[p] ^ {16'h0, 8'(k), 8'h3C});
        check_all(tag);
      end

    // R10: same-cycle read of a register being written returns the old value
    @(negedge clk);
    addr = 13'h1; wdata = 32'hDEAD_BEEF; we = 1'b1; re = 1'b1; #1;
    chk("R10 pre-write read", rdata, mp[1]);
    @(negedge clk);
    we = 1'b0; re = 1'b0; model_write(13'h1, 32'hDEAD_BEEF); #1;
    chk("R10 post-write read", rdata, 32'hDEAD_BEEF);
    @(negedge clk);
    addr = 13'h1005; wdata = 32'h0000_F000; we = 1'b1; #1;
    chk("R10 pre-set read", rdata, ma[4]);
    @(negedge clk);
    we = 1'b0; model_write(13'h1005, 32'h0000_F000); #1;
    chk("R10 post-set read", rdata, ma[4]);

    // R9: out-of-range writes and reads
    for (int i = 0; i < 5; i++) begin
      bus_write(oor[i], 32'h1234_5678);
      chk("R9 err on write", {31'b0, err}, 32'h1);
      @(negedge clk);
      chk("R9 err one cycle", {31'b0, err}, 32'h0);
      addr = oor[i]; re = 1'b1; #1;
      chk("R9 read zero", rdata, 32'h0);
      @(negedge clk);
      re = 1'b0;
      chk("R9 err on read", {31'b0, err}, 32'h1);
      @(negedge clk);
      chk("R9 err drop", {31'b0, err}, 32'h0);
      check_all("R9 no effect");
    end

    // R8: lock bit cleared through the clear slot comes back on reset
    bus_write(13'h1002, 32'h8000_0000);
    bus_write(13'h1006, 32'hFFFF_FFFF);
    chk("R4 lock cleared", alias_regs[31:0] & 32'h8000_0000, 32'h0);
    do_reset();
    check_all("R8 second reset");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule